// File: doc/BRIEF.md
# Normalized Vector Packer

This block converts a vector of up to four single-precision floating-point lanes into one 32-bit word of normalized fixed-point fields. A two-bit format code picks the field layout: two signed 16-bit fields, four signed 8-bit fields, two unsigned 16-bit fields or four unsigned 8-bit fields. Each lane is clamped to the format's range, scaled by that format's full-scale integer (2^n − 1, where n is the number of magnitude bits in the field) and rounded to the nearest integer. The conversion uses only shifts, adds and compares. There is no floating-point macro.

Vectors enter through a valid/ready handshake. The result is held in a single output register, which is controlled by a two-state machine. In state `ST_EMPTY` the register holds nothing, and in state `ST_FULL` it holds a word that the consumer has not yet taken. The machine has four transitions:

- *load*: EMPTY→FULL on an accepted input.
- *drain*: FULL→EMPTY when the word is taken and no new input arrives.
- *swap*: FULL→FULL when the word is taken and a new input is accepted in the same cycle.
- *hold*: FULL→FULL while the consumer stalls.

EMPTY stays EMPTY while no input arrives. Reset forces `ST_EMPTY`.

Top module: `nvp_packer`

## Requirements
- R1: Format code 0 gives two signed 16-bit fields. Each lane is clamped to [−1, +1], multiplied by 32767 and rounded.
- R2: Format code 1 gives four signed 8-bit fields. Each lane is clamped to [−1, +1], multiplied by 127 and rounded.
- R3: Format code 2 gives two unsigned 16-bit fields. Each lane is clamped to [0, 1], multiplied by 65535 and rounded.
- R4: Format code 3 gives four unsigned 8-bit fields. Each lane is clamped to [0, 1], multiplied by 255 and rounded.
- R5: A scaled value that lies exactly halfway between two integers rounds to the even one. For example, −0.5 in format 1 gives −64 (0xC0) and +0.5 gives 64 (0x40).
- R6: Lane i occupies bits [i·W +: W] of the output word, where W is the field width (16 or 8). Lane 0 is therefore the least significant field.
- R7: Signed fields are two's complement, masked to the field width before placement. For example, −1.0 in format 0 gives 0x8001, and a negative lane never changes the bits of a neighbouring field.
- R8: A NaN lane (exponent all ones, mantissa non-zero) gives a zero field, whatever its sign.
- R9: An infinite lane saturates to the clamp bound of the format in use. For example, +inf gives 0x7F in format 1 and −inf gives 0 in format 3.
- R10: A lane with a zero exponent (zero or denormal) gives a zero field.
- R11: In formats 0 and 2, lanes 2 and 3 have no effect on the output word.
- R12: `in_ready` is high whenever the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_word` and `out_valid` stay unchanged.
- R13: After reset, `out_valid` is low and `in_ready` is high.
- R14: A vector accepted at a clock edge appears on `out_word`, with `out_valid` high, directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Unit can accept a vector this cycle |
| in_mode | input | 2 | Format code 0..3 |
| in_lanes | input | 128 | Lane i in bits [32i +: 32], single precision |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | 32 | Packed fields |

## Verification
The drain of the held word and the load of a new word can fall in the same cycle, which is the *swap* transition. When that happens the register must replace its contents without dropping or repeating a vector. The bench first streams with `out_ready` held high and `in_valid` continuous, so every cycle is a swap. It then mixes periodic consumer stalls with gaps in the input, which exercises all four transitions. Each delivered word is compared in order against a queue of words computed in real arithmetic from the requirements, and the word held during a stall is compared against its value before the stall.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
    localparam int LANES     = 4;
    localparam int FLT_W     = 32;
    localparam int EXP_W     = 8;
    localparam int MAN_W     = 23;
    localparam int WORD_W    = 32;
    localparam int FIELD_MAX = 16;
    localparam int SIG_W     = MAN_W + 1;
    localparam int PROD_W    = SIG_W + FIELD_MAX;
    localparam int MAG_W     = FIELD_MAX + 1;
    localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX   = (1 << EXP_W) - 1;
    localparam int SH_BASE   = BIAS + MAN_W;
    localparam int MIN_EXP   = SH_BASE - PROD_W;

    typedef enum logic [1:0] {
        FMT_S16 = 2'd0,
        FMT_S8  = 2'd1,
        FMT_U16 = 2'd2,
        FMT_U8  = 2'd3
    } fmt_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;
endpackage

// File: rtl/nvp_lane_cvt.sv
module nvp_lane_cvt
    import nvp_pkg::*;
(
    input  logic [FLT_W-1:0]     lane_i,
    input  fmt_e                 fmt_i,
    output logic [FIELD_MAX-1:0] field_o
);
    localparam int HALF_W = FIELD_MAX / 2;

    logic                 sgn;
    logic [EXP_W-1:0]     expo;
    logic [MAN_W-1:0]     man;
    logic                 signed_f, wide_f;
    logic [4:0]           nbits;
    logic [MAG_W-1:0]     fullscale;
    logic [PROD_W-1:0]    sig_x, prod, quot, one;
    logic [8:0]           kfull;
    logic [5:0]           k;
    logic                 halfb, sticky, up;
    logic [MAG_W-1:0]     mag_rnd, mag;
    logic [FIELD_MAX-1:0] val;

    assign sgn  = lane_i[FLT_W-1];
    assign expo = lane_i[FLT_W-2 -: EXP_W];
    assign man  = lane_i[MAN_W-1:0];

    always_comb begin
        unique case (fmt_i)
            FMT_S16: begin signed_f = 1'b1; wide_f = 1'b1; nbits = 5'd15; end
            FMT_S8:  begin signed_f = 1'b1; wide_f = 1'b0; nbits = 5'd7;  end
            FMT_U16: begin signed_f = 1'b0; wide_f = 1'b1; nbits = 5'd16; end
            default: begin signed_f = 1'b0; wide_f = 1'b0; nbits = 5'd8;  end
        endcase
    end

    // scale = 2^n - 1, applied as (sig << n) - sig
    assign fullscale = (MAG_W'(1) << nbits) - MAG_W'(1);
    assign sig_x     = PROD_W'({1'b1, man});
    assign prod      = (sig_x << nbits) - sig_x;
    assign kfull     = 9'(SH_BASE) - {1'b0, expo};
    assign k         = kfull[5:0];
    assign one       = PROD_W'(1);
    assign quot      = prod >> k;
    assign halfb     = |(prod & (one << (k - 6'd1)));
    assign sticky    = |(prod & ((one << (k - 6'd1)) - one));
    assign up        = halfb & (sticky | quot[0]);
    assign mag_rnd   = quot[MAG_W-1:0] + MAG_W'(up);

    always_comb begin
        if (expo == EXP_W'(EXP_MAX)) begin
            mag = (man != '0) ? '0 : fullscale;
        end else if (expo == '0) begin
            mag = '0;
        end else if (expo >= EXP_W'(BIAS)) begin
            mag = fullscale;
        end else if (expo < EXP_W'(MIN_EXP)) begin
            mag = '0;
        end else begin
            mag = mag_rnd;
        end
    end

    always_comb begin
        if (sgn && !signed_f)
            val = '0;
        else if (sgn)
            val = ~mag[FIELD_MAX-1:0] + FIELD_MAX'(1);
        else
            val = mag[FIELD_MAX-1:0];
        field_o = wide_f ? val : {{HALF_W{1'b0}}, val[HALF_W-1:0]};
    end
endmodule

// File: rtl/nvp_word_pack.sv
module nvp_word_pack
    import nvp_pkg::*;
(
    input  logic [LANES*FIELD_MAX-1:0] fields_i,
    input  fmt_e                       fmt_i,
    output logic [WORD_W-1:0]          word_o
);
    localparam int NARROW_W = WORD_W / LANES;
    localparam int WIDE_N   = WORD_W / FIELD_MAX;

    logic [WORD_W-1:0] narrow_w, wide_w;

    for (genvar g = 0; g < LANES; g++) begin : g_narrow
        assign narrow_w[g*NARROW_W +: NARROW_W] = fields_i[g*FIELD_MAX +: NARROW_W];
    end
    for (genvar g = 0; g < WIDE_N; g++) begin : g_wide
        assign wide_w[g*FIELD_MAX +: FIELD_MAX] = fields_i[g*FIELD_MAX +: FIELD_MAX];
    end

    assign word_o = (fmt_i == FMT_S16 || fmt_i == FMT_U16) ? wide_w : narrow_w;
endmodule

// File: rtl/nvp_out_stage.sv
module nvp_out_stage
    import nvp_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_req,
    input  logic [W-1:0] data_i,
    output logic         load_ok,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] data_o
);
    stage_e state, state_nx;
    logic   take, load;

    assign take = (state == ST_FULL) && out_ready;
    assign load = load_req && load_ok;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (load) data_o <= data_i;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (load_req)                   state_nx = ST_FULL;   // load
            ST_FULL:  if (out_ready && !load_req)     state_nx = ST_EMPTY;  // drain
                      else                            state_nx = ST_FULL;   // swap or hold
            default:                                  state_nx = ST_EMPTY;
        endcase
    end

    always_comb begin
        out_valid = (state == ST_FULL);
        load_ok   = (state == ST_EMPTY) || take;
    end
endmodule

// File: rtl/nvp_packer.sv
module nvp_packer
    import nvp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [1:0]              in_mode,
    input  logic [LANES*FLT_W-1:0]  in_lanes,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [WORD_W-1:0]       out_word
);
    fmt_e                       fmt;
    logic [LANES*FIELD_MAX-1:0] fields;
    logic [WORD_W-1:0]          packed_w;

    assign fmt = fmt_e'(in_mode);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        nvp_lane_cvt u_cvt (
            .lane_i  (in_lanes[g*FLT_W +: FLT_W]),
            .fmt_i   (fmt),
            .field_o (fields[g*FIELD_MAX +: FIELD_MAX])
        );
    end

    nvp_word_pack u_pack (
        .fields_i (fields),
        .fmt_i    (fmt),
        .word_o   (packed_w)
    );

    nvp_out_stage #(.W(WORD_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .load_req  (in_valid),
        .data_i    (packed_w),
        .load_ok   (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .data_o    (out_word)
    );
endmodule

// File: rtl/nvp_checks.sv
module nvp_checks
    import nvp_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic [1:0]             in_mode,
    input logic [LANES*FLT_W-1:0] in_lanes,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [WORD_W-1:0]      out_word
);
    logic lane0_nan;
    assign lane0_nan = (in_lanes[FLT_W-2 -: EXP_W] == EXP_W'(EXP_MAX)) &&
                       (in_lanes[MAN_W-1:0] != '0);

    p_hold_stable_r12: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_word));

    p_empty_ready_r12: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    p_accept_shows_r14: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    p_drain_empties_r12: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !in_valid |=> !out_valid);

    p_nan_zero_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && lane0_nan |=> out_word[7:0] == 8'h00);

    p_wide_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !in_mode[0] && lane0_nan |=> out_word[15:0] == 16'h0000);
endmodule

bind nvp_packer nvp_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mode   (in_mode),
    .in_lanes  (in_lanes),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
);

// File: tb/test_nvp_packer.sv
`timescale 1ns/100ps
module test_nvp_packer;
    localparam int NSW    = 151;
    localparam int NSP    = 9;
    localparam int NITEMS = 4 * NSW + NSP;
    localparam int WD     = 20000;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid, in_ready, out_valid, out_ready;
    logic [1:0]   in_mode;
    logic [127:0] in_lanes;
    logic [31:0]  out_word;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    nvp_packer i_nvp_packer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_lanes(in_lanes), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // single-precision bits of i/256
    function automatic logic [31:0] dy(input int i);
        int mag, p;
        logic s;
        s   = (i < 0);
        mag = s ? -i : i;
        if (mag == 0) return {s, 31'd0};
        p = 0;
        for (int b = 0; b < 16; b++) if (mag >= (1 << b)) p = b;
        return {s, 8'(127 + p - 8), 23'((mag << (23 - p)) & 32'h7FFFFF)};
    endfunction

    function automatic int ref_field(input logic [31:0] b, input int mode);
        int e, m, ip, wmask;
        real r, scale, lo, v, fl;
        e = int'(b[30:23]);
        m = int'(b[22:0]);
        scale = (mode == 0) ? 32767.0 : (mode == 1) ? 127.0 : (mode == 2) ? 65535.0 : 255.0;
        lo    = (mode < 2) ? -1.0 : 0.0;
        wmask = (mode == 0 || mode == 2) ? 32'hFFFF : 32'hFF;
        if (e == 255 && m != 0) return 0;       // R8
        if (e == 0) return 0;                   // R10
        if (e == 255) r = b[31] ? -2.0 : 2.0;   // R9 via clamp
        else begin
            r = 1.0 + real'(m) / 8388608.0;
            if (e >= 127) for (int j = 127; j < e; j++) r = r * 2.0;
            else          for (int j = e; j < 127; j++) r = r / 2.0;
            if (b[31]) r = -r;
        end
        if (r > 1.0) r = 1.0;
        if (r < lo)  r = lo;
        v  = r * scale;
        fl = $floor(v);
        ip = $rtoi(fl);
        if (v - fl > 0.5) ip = ip + 1;
        else if (v - fl == 0.5 && (ip % 2) != 0) ip = ip + 1;  // R5
        return ip & wmask;
    endfunction

    function automatic logic [31:0] ref_word(input logic [127:0] l, input int mode);
        logic [31:0] w;
        w = '0;
        if (mode == 0 || mode == 2) begin
            for (int j = 0; j < 2; j++) w[j*16 +: 16] = 16'(ref_field(l[j*32 +: 32], mode));
        end else begin
            for (int j = 0; j < 4; j++) w[j*8 +: 8] = 8'(ref_field(l[j*32 +: 32], mode));
        end
        return w;
    endfunction

    task automatic make_item(input int t, output logic [127:0] l, output int mode, output string tag);
        int grp;
        if (t < 4 * NSW) begin
            mode = t / NSW;
            grp  = t % NSW;
            for (int j = 0; j < 4; j++) l[j*32 +: 32] = dy(grp * 4 + j - 300);
            tag = (mode == 0) ? "R1" : (mode == 1) ? "R2" : (mode == 2) ? "R3" : "R4";
        end else begin
            case (t - 4 * NSW)
                0: begin mode = 1; tag = "R5";  l = {32'h3F800000, 32'hBF800000, 32'h3F000000, 32'hBF000000}; end
                1: begin mode = 0; tag = "R7";  l = {dy(5), dy(7), dy(-3), 32'hBF800000}; end
                2: begin mode = 1; tag = "R7";  l = {dy(-1), 32'hBF800000, dy(-200), dy(-2)}; end
                3: begin mode = 3; tag = "R6";  l = {dy(4), dy(3), dy(2), dy(1)}; end
                4: begin mode = 0; tag = "R8";  l = {32'h7F800000, 32'h7F800000, 32'hFFC00001, 32'h7FC00000}; end
                5: begin mode = 1; tag = "R9";  l = {32'hC0400000, 32'h40000000, 32'hFF800000, 32'h7F800000}; end
                6: begin mode = 3; tag = "R9";  l = {32'h7F800000, dy(1), 32'h7F800000, 32'hFF800000}; end
                7: begin mode = 3; tag = "R10"; l = {32'h3F000000, 32'h00800000, 32'h80400000, 32'h00000001}; end
                default: begin mode = 2; tag = "R11"; l = {32'h7F800000, 32'h7FC00000, 32'h3F400000, 32'h3F000000}; end
            endcase
        end
    endtask

    logic [31:0] exp_q[$];
    string       tag_q[$];

    initial begin
        int cyc, idx, rcv, mode;
        logic acc_prev, held_prev;
        logic [31:0] held_word;
        logic [127:0] l;
        string tag;

        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_mode = '0; in_lanes = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R13 out_valid", 32'(out_valid), 32'd0);
        check("R13 in_ready", 32'(in_ready), 32'd1);

        cyc = 0; idx = 0; rcv = 0; acc_prev = 0; held_prev = 0; held_word = '0;
        while (rcv < NITEMS && cyc < WD) begin
            @(negedge clk);
            cyc++;
            out_ready = (cyc < 400) ? 1'b1 : ((cyc % 3) != 0);
            if (idx < NITEMS && !(cyc >= 400 && (cyc % 5) == 2)) begin
                make_item(idx, l, mode, tag);
                in_valid = 1'b1; in_lanes = l; in_mode = 2'(mode);
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (acc_prev) check("R14 out_valid after accept", 32'(out_valid), 32'd1);
            if (held_prev) check("R12 stall hold", out_word, held_word);
            if (!out_valid) check("R12 ready while empty", 32'(in_ready), 32'd1);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R12 unexpected word", out_word, 32'hDEADBEEF);
                end else begin
                    check(tag_q.pop_front(), out_word, exp_q.pop_front());
                end
                rcv++;
            end
            held_prev = out_valid && !out_ready;
            held_word = out_word;
            acc_prev  = in_valid && in_ready;
            if (acc_prev) begin
                make_item(idx, l, mode, tag);
                exp_q.push_back(ref_word(l, mode));
                tag_q.push_back(tag);
                idx++;
            end
        end
        if (cyc >= WD) begin
            errors++; checks++;
            $display("FAIL watchdog received=%0d expected=%0d", rcv, NITEMS);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule